// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a table of memory groups for an out-of-order scheduler. A group is a set of memory operations with no ordering among themselves. Groups are ordered against one another by successor links. Each group holds six counters. Three count its predecessor groups: all of them, those still executing, and those that have finished. The other three count its own instructions: all of them, those issued, and those completed. From these counters the block derives whether a group must still wait, is only pending on predecessors already in flight, or is ready to execute.

The scheduler drives one operation per cycle on a single command port. It can add an instruction to a group, link one group ahead of another, signal that an instruction of a group has issued, or signal that an instruction has completed. When a group starts executing, each of its successors learns this; when it finishes, each successor moves that predecessor from the in-flight count to the finished count. Each group also keeps an estimate of the cycles left on its slowest in-flight predecessor, which counts down while the group waits. A combinational query port shows any group's state. A sticky error flag records any operation that was not allowed.

Top module: `mdg_tracker`

## Requirements
- R1: After reset every group has all six counters at zero, a dependency state of ready, the executed flag set, a critical count of zero, and the error flag clear.
- R2: Operation code 0 (add) increments the instruction count of group `op_gid`. It is illegal when `op_gid` is 0, the group already has a successor, or the count is at its maximum of 15.
- R3: Operation code 1 (link) makes group `op_peer` a successor of group `op_gid` and increments the successor's predecessor count. If `op_gid` is executing at that moment, the successor's executing-predecessor count also increments and its critical count is raised to the source group's largest issued cycle value. It is illegal for ID 0, for a self-link, for a source with no instruction left to complete, for a duplicate link, or when the predecessor count is at 15.
- R4: Operation code 2 (issue) increments the issued count and records the largest `op_cyc` seen by the group. When all of the group's unfinished instructions are then issued, the group is executing, and every successor increments its executing-predecessor count. It is illegal when the group has no unissued instruction.
- R5: Operation code 3 (done) moves one instruction from issued to completed. It is legal only when the group is ready and has an issued instruction. When the last instruction completes, every successor moves one predecessor from executing to executed.
- R6: `qry_dep` encodes waiting as 0 (predecessors exceed executing plus executed predecessors), pending as 1 (none unaccounted for and at least one executing), and ready as 2 (executed predecessors equal the total). `qry_executing` is set when the issued count is nonzero and equals instructions minus completed. `qry_executed` is set when completed equals instructions.
- R7: On every clock edge, a waiting group with a nonzero critical count decrements it by one. If the same edge delivers a larger value from a predecessor that starts executing, or from a link to an executing source, the count takes that value instead. Otherwise the count holds.
- R8: An illegal operation sets the sticky error flag and changes no counter or link. The flag clears only on reset.
- R9: The effect of an operation at a clock edge is visible at the query port for any group from that edge on, under arbitrary mixes of legal and illegal operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 add, 1 link, 2 issue, 3 done |
| op_gid | input | 4 | Target group (source group for link) |
| op_peer | input | 4 | Successor group for link |
| op_cyc | input | 8 | Remaining cycles of the issuing instruction |
| qry_gid | input | 4 | Group shown on the query outputs |
| qry_dep | output | 2 | Dependency state of the queried group |
| qry_executing | output | 1 | Queried group is executing |
| qry_executed | output | 1 | Queried group has completed all instructions |
| qry_crit | output | 8 | Critical-predecessor cycle estimate |
| qry_pred | output | 4 | Predecessor count |
| qry_pred_exec | output | 4 | Executing-predecessor count |
| qry_pred_done | output | 4 | Executed-predecessor count |
| qry_inst | output | 4 | Instruction count |
| qry_issued | output | 4 | Issued, not yet completed, instructions |
| qry_done | output | 4 | Completed instructions |
| err | output | 1 | Sticky illegal-operation flag |

## Verification
The assertions assume that `op_valid` and `op_kind` are always known values. They also assume that at most one operation arrives per cycle, which the single command port enforces, so a group hears from at most one predecessor per edge. No assumption is made about legality: the stimulus includes group 0, self-links, duplicate links, over-completion and counter saturation on purpose, so the error path and the counter invariants are exercised. Inputs change only on the falling edge. Directed sequences and a long pseudo-random run over groups 0 to 7 are compared after every edge against a counter model of all fifteen usable groups, with periodic resets so that legal traffic keeps building state.

// File: rtl/mdg_pkg.sv
`timescale 1ns/1ps
package mdg_pkg;
    localparam int GRP_N = 16;
    localparam int CNT_W = 4;
    localparam int CYC_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_LINK  = 2'd1,
        OP_ISSUE = 2'd2,
        OP_DONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        DEP_WAIT  = 2'd0,
        DEP_PEND  = 2'd1,
        DEP_READY = 2'd2
    } dep_e;

    typedef struct packed {
        cnt_t pred;
        cnt_t pexe;
        cnt_t pdone;
        cnt_t inst;
        cnt_t iss;
        cnt_t done;
    } grp_cnt_t;

    function automatic logic [CNT_W:0] add2(cnt_t a, cnt_t b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    function automatic dep_e dep_of(grp_cnt_t c);
        if ({1'b0, c.pred} > add2(c.pexe, c.pdone)) return DEP_WAIT;
        if (c.pexe != '0) return DEP_PEND;
        return DEP_READY;
    endfunction

    function automatic logic busy(grp_cnt_t c);
        return (c.iss != '0) && (add2(c.iss, c.done) == {1'b0, c.inst});
    endfunction

    function automatic logic finished(grp_cnt_t c);
        return c.done == c.inst;
    endfunction

    function automatic logic [CYC_W-1:0] cyc_max(logic [CYC_W-1:0] a, logic [CYC_W-1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/mdg_slot.sv
`timescale 1ns/1ps
module mdg_slot
    import mdg_pkg::*;
#(
    parameter int GROUPS = mdg_pkg::GRP_N,
    parameter int GID_W  = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_inst,
    input  logic              set_succ,
    input  logic [GID_W-1:0]  succ_idx,
    input  logic              iss_inc,
    input  logic [CYC_W-1:0]  iss_cyc,
    input  logic              done_inc,
    input  logic              pred_add,
    input  logic              pred_add_exec,
    input  logic              pred_start,
    input  logic              pred_finish,
    input  logic              raise_vld,
    input  logic [CYC_W-1:0]  raise_val,
    output grp_cnt_t          cnt_q,
    output logic [GROUPS-1:0] succ_q,
    output logic [CYC_W-1:0]  crit_q,
    output logic [CYC_W-1:0]  self_q
);
    logic waiting;
    assign waiting = (dep_of(cnt_q) == DEP_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            succ_q <= '0;
            crit_q <= '0;
            self_q <= '0;
        end else begin
            if (inc_inst) cnt_q.inst <= cnt_q.inst + 1'b1;
            if (set_succ) succ_q[succ_idx] <= 1'b1;
            if (iss_inc) begin
                cnt_q.iss <= cnt_q.iss + 1'b1;
                self_q    <= cyc_max(self_q, iss_cyc);
            end
            if (done_inc) begin
                cnt_q.iss  <= cnt_q.iss - 1'b1;
                cnt_q.done <= cnt_q.done + 1'b1;
            end
            if (pred_add) cnt_q.pred <= cnt_q.pred + 1'b1;
            if (pred_add_exec || pred_start) begin
                cnt_q.pexe <= cnt_q.pexe + 1'b1;
            end else if (pred_finish) begin
                cnt_q.pexe  <= cnt_q.pexe - 1'b1;
                cnt_q.pdone <= cnt_q.pdone + 1'b1;
            end
            if (raise_vld && (raise_val > crit_q)) begin
                crit_q <= raise_val;
            end else if (waiting && (crit_q != '0)) begin
                crit_q <= crit_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdg_rules.sv
`timescale 1ns/1ps
module mdg_rules
    import mdg_pkg::*;
#(
    parameter int GROUPS = mdg_pkg::GRP_N,
    parameter int GID_W  = $clog2(GROUPS)
) (
    input  op_e               kind,
    input  logic [GID_W-1:0]  gid,
    input  logic [GID_W-1:0]  peer,
    input  grp_cnt_t          src,
    input  logic [GROUPS-1:0] src_succ,
    input  grp_cnt_t          dst,
    output logic              legal,
    output logic              src_busy,
    output logic              goes_busy,
    output logic              goes_done
);
    logic gid_ok;
    logic peer_ok;

    always_comb begin
        gid_ok    = (gid != '0);
        peer_ok   = (peer != '0) && (peer != gid);
        src_busy  = busy(src);
        goes_busy = ((add2(src.iss, src.done) + 1'b1) == {1'b0, src.inst});
        goes_done = (({1'b0, src.done} + 1'b1) == {1'b0, src.inst});
        case (kind)
            OP_ADD:   legal = gid_ok && (src_succ == '0) && (src.inst != '1);
            OP_LINK:  legal = gid_ok && peer_ok && !finished(src)
                              && !src_succ[peer] && (dst.pred != '1);
            OP_ISSUE: legal = gid_ok && (add2(src.iss, src.done) < {1'b0, src.inst});
            OP_DONE:  legal = gid_ok && (dep_of(src) == DEP_READY) && (src.iss != '0);
            default:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mdg_query.sv
`timescale 1ns/1ps
module mdg_query
    import mdg_pkg::*;
#(
    parameter int GROUPS = mdg_pkg::GRP_N,
    parameter int GID_W  = $clog2(GROUPS)
) (
    input  logic [GID_W-1:0] sel,
    input  grp_cnt_t         cnt_a  [GROUPS],
    input  logic [CYC_W-1:0] crit_a [GROUPS],
    output grp_cnt_t         cnt_o,
    output logic [CYC_W-1:0] crit_o
);
    assign cnt_o  = cnt_a[sel];
    assign crit_o = crit_a[sel];
endmodule

// File: rtl/mdg_tracker.sv
`timescale 1ns/1ps
module mdg_tracker
    import mdg_pkg::*;
#(
    parameter int GROUPS = mdg_pkg::GRP_N,
    parameter int GID_W  = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [GID_W-1:0] op_gid,
    input  logic [GID_W-1:0] op_peer,
    input  logic [CYC_W-1:0] op_cyc,
    input  logic [GID_W-1:0] qry_gid,
    output logic [1:0]       qry_dep,
    output logic             qry_executing,
    output logic             qry_executed,
    output logic [CYC_W-1:0] qry_crit,
    output logic [CNT_W-1:0] qry_pred,
    output logic [CNT_W-1:0] qry_pred_exec,
    output logic [CNT_W-1:0] qry_pred_done,
    output logic [CNT_W-1:0] qry_inst,
    output logic [CNT_W-1:0] qry_issued,
    output logic [CNT_W-1:0] qry_done,
    output logic             err
);
    grp_cnt_t          cnt_a  [GROUPS];
    logic [GROUPS-1:0] succ_a [GROUPS];
    logic [CYC_W-1:0]  crit_a [GROUPS];
    logic [CYC_W-1:0]  self_a [GROUPS];
    dep_e              dep_a  [GROUPS];

    op_e               kind;
    logic              legal;
    logic              fire;
    logic              src_busy;
    logic              goes_busy;
    logic              goes_done;
    logic [CYC_W-1:0]  new_self;
    grp_cnt_t          q_cnt;

    assign kind     = op_e'(op_kind);
    assign fire     = op_valid && legal;
    assign new_self = cyc_max(self_a[op_gid], op_cyc);

    mdg_rules #(.GROUPS(GROUPS), .GID_W(GID_W)) rules_i (
        .kind      (kind),
        .gid       (op_gid),
        .peer      (op_peer),
        .src       (cnt_a[op_gid]),
        .src_succ  (succ_a[op_gid]),
        .dst       (cnt_a[op_peer]),
        .legal     (legal),
        .src_busy  (src_busy),
        .goes_busy (goes_busy),
        .goes_done (goes_done)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_slot
        logic own;
        logic is_peer;
        logic link_in;
        logic link_exec;
        logic start_in;
        assign own       = (op_gid == GID_W'(g));
        assign is_peer   = (op_peer == GID_W'(g));
        assign link_in   = fire && (kind == OP_LINK) && is_peer;
        assign link_exec = link_in && src_busy;
        assign start_in  = fire && (kind == OP_ISSUE) && goes_busy && succ_a[op_gid][g];

        mdg_slot #(.GROUPS(GROUPS), .GID_W(GID_W)) slot_i (
            .clk           (clk),
            .rst           (rst),
            .inc_inst      (fire && (kind == OP_ADD) && own),
            .set_succ      (fire && (kind == OP_LINK) && own),
            .succ_idx      (op_peer),
            .iss_inc       (fire && (kind == OP_ISSUE) && own),
            .iss_cyc       (op_cyc),
            .done_inc      (fire && (kind == OP_DONE) && own),
            .pred_add      (link_in),
            .pred_add_exec (link_exec),
            .pred_start    (start_in),
            .pred_finish   (fire && (kind == OP_DONE) && goes_done && succ_a[op_gid][g]),
            .raise_vld     (link_exec || start_in),
            .raise_val     (link_exec ? self_a[op_gid] : new_self),
            .cnt_q         (cnt_a[g]),
            .succ_q        (succ_a[g]),
            .crit_q        (crit_a[g]),
            .self_q        (self_a[g])
        );

        assign dep_a[g] = dep_of(cnt_a[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (op_valid && !legal) begin
            err <= 1'b1;
        end
    end

    mdg_query #(.GROUPS(GROUPS), .GID_W(GID_W)) query_i (
        .sel    (qry_gid),
        .cnt_a  (cnt_a),
        .crit_a (crit_a),
        .cnt_o  (q_cnt),
        .crit_o (qry_crit)
    );

    assign qry_dep       = dep_of(q_cnt);
    assign qry_executing = busy(q_cnt);
    assign qry_executed  = finished(q_cnt);
    assign qry_pred      = q_cnt.pred;
    assign qry_pred_exec = q_cnt.pexe;
    assign qry_pred_done = q_cnt.pdone;
    assign qry_inst      = q_cnt.inst;
    assign qry_issued    = q_cnt.iss;
    assign qry_done      = q_cnt.done;
endmodule

// File: rtl/mdg_tracker_chk.sv
`timescale 1ns/1ps
module mdg_tracker_chk
    import mdg_pkg::*;
#(
    parameter int GROUPS = mdg_pkg::GRP_N
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             legal,
    input logic             err,
    input grp_cnt_t         cnt_a  [GROUPS],
    input dep_e             dep_a  [GROUPS],
    input logic [CYC_W-1:0] crit_a [GROUPS]
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R8

    AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !legal) |=> err); // R8

    AST_GROUP0_IDLE: assert property (@(posedge clk) disable iff (rst)
        cnt_a[0] == '0); // R8

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        AST_PRED_SUM: assert property (@(posedge clk) disable iff (rst)
            add2(cnt_a[g].pexe, cnt_a[g].pdone) <= {1'b0, cnt_a[g].pred}); // R6

        AST_ISSUE_BOUND: assert property (@(posedge clk) disable iff (rst)
            add2(cnt_a[g].iss, cnt_a[g].done) <= {1'b0, cnt_a[g].inst}); // R4

        AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
            (cnt_a[g].done != $past(cnt_a[g].done)) |-> ($past(dep_a[g]) == DEP_READY)); // R5

        AST_CRIT_DECR: assert property (@(posedge clk) disable iff (rst)
            (!op_valid && dep_a[g] == DEP_WAIT && crit_a[g] != '0)
            |=> (crit_a[g] == $past(crit_a[g]) - 1'b1)); // R7

        AST_CRIT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!op_valid && dep_a[g] != DEP_WAIT) |=> $stable(crit_a[g])); // R7
    end
endmodule

bind mdg_tracker mdg_tracker_chk #(.GROUPS(GROUPS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .legal    (legal),
    .err      (err),
    .cnt_a    (cnt_a),
    .dep_a    (dep_a),
    .crit_a   (crit_a)
);

// File: tb/mdg_tracker_tb_top.sv
`timescale 1ns/1ps
module mdg_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [3:0] op_gid = 4'd0;
    logic [3:0] op_peer = 4'd0;
    logic [7:0] op_cyc = 8'd0;
    logic [3:0] qry_gid = 4'd0;
    logic [1:0] qry_dep;
    logic       qry_executing;
    logic       qry_executed;
    logic [7:0] qry_crit;
    logic [3:0] qry_pred, qry_pred_exec, qry_pred_done, qry_inst, qry_issued, qry_done;
    logic       err;

    mdg_tracker dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_gid(op_gid), .op_peer(op_peer), .op_cyc(op_cyc), .qry_gid(qry_gid),
        .qry_dep(qry_dep), .qry_executing(qry_executing), .qry_executed(qry_executed),
        .qry_crit(qry_crit), .qry_pred(qry_pred), .qry_pred_exec(qry_pred_exec),
        .qry_pred_done(qry_pred_done), .qry_inst(qry_inst), .qry_issued(qry_issued),
        .qry_done(qry_done), .err(err)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished_run = 0;

    int m_pred[16], m_pe[16], m_pd[16], m_ni[16], m_nx[16], m_nd[16];
    int m_crit[16], m_self[16];
    bit m_succ[16][16];
    bit m_err;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            m_pred[i] = 0; m_pe[i] = 0; m_pd[i] = 0;
            m_ni[i] = 0; m_nx[i] = 0; m_nd[i] = 0;
            m_crit[i] = 0; m_self[i] = 0;
            for (int j = 0; j < 16; j++) m_succ[i][j] = 0;
        end
        m_err = 0;
    endtask

    function automatic bit m_busy(int g);
        return (m_nx[g] != 0) && (m_nx[g] == m_ni[g] - m_nd[g]);
    endfunction

    function automatic int m_dep(int g);
        if (m_pred[g] > m_pe[g] + m_pd[g]) return 0;
        if (m_pe[g] != 0) return 1;
        return 2;
    endfunction

    function automatic bit any_succ(int g);
        for (int j = 0; j < 16; j++) if (m_succ[g][j]) return 1;
        return 0;
    endfunction

    task automatic sweep(input string tag);
        for (int h = 1; h < 16; h++) begin
            qry_gid = 4'(h);
            #0.1;
            chk(tag, "dep", int'(qry_dep), m_dep(h));
            chk(tag, "executing", int'(qry_executing), int'(m_busy(h)));
            chk(tag, "executed", int'(qry_executed), int'(m_nd[h] == m_ni[h]));
            chk(tag, "crit", int'(qry_crit), m_crit[h]);
            chk(tag, "pred", int'(qry_pred), m_pred[h]);
            chk(tag, "pred_exec", int'(qry_pred_exec), m_pe[h]);
            chk(tag, "pred_done", int'(qry_pred_done), m_pd[h]);
            chk(tag, "inst", int'(qry_inst), m_ni[h]);
            chk(tag, "issued", int'(qry_issued), m_nx[h]);
            chk(tag, "done", int'(qry_done), m_nd[h]);
        end
        chk(tag, "err", int'(err), int'(m_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        #1;
        sweep("R1");
    endtask

    task automatic step(input bit v, input int k, input int g, input int p, input int c,
                        input string tag);
        bit ok;
        bit rf[16];
        int rv[16];
        bit wt[16];
        @(negedge clk);
        op_valid = v;
        op_kind  = 2'(k);
        op_gid   = 4'(g);
        op_peer  = 4'(p);
        op_cyc   = 8'(c);
        for (int h = 0; h < 16; h++) begin
            rf[h] = 0; rv[h] = 0; wt[h] = (m_dep(h) == 0);
        end
        ok = 0;
        case (k)
            0: ok = (g != 0) && !any_succ(g) && (m_ni[g] < 15);
            1: ok = (g != 0) && (p != 0) && (p != g) && (m_nd[g] != m_ni[g])
                    && !m_succ[g][p] && (m_pred[p] < 15);
            2: ok = (g != 0) && (m_nx[g] + m_nd[g] < m_ni[g]);
            default: ok = (g != 0) && (m_dep(g) == 2) && (m_nx[g] != 0);
        endcase
        if (v && !ok) m_err = 1;
        if (v && ok) begin
            case (k)
                0: m_ni[g]++;
                1: begin
                    if (m_busy(g)) begin
                        m_pe[p]++; rf[p] = 1; rv[p] = m_self[g];
                    end
                    m_succ[g][p] = 1;
                    m_pred[p]++;
                end
                2: begin
                    bit goes;
                    goes = (m_nx[g] + 1 == m_ni[g] - m_nd[g]);
                    m_nx[g]++;
                    if (c > m_self[g]) m_self[g] = c;
                    if (goes)
                        for (int s = 0; s < 16; s++)
                            if (m_succ[g][s]) begin
                                m_pe[s]++; rf[s] = 1; rv[s] = m_self[g];
                            end
                end
                default: begin
                    bit fin;
                    fin = (m_nd[g] + 1 == m_ni[g]);
                    m_nx[g]--;
                    m_nd[g]++;
                    if (fin)
                        for (int s = 0; s < 16; s++)
                            if (m_succ[g][s]) begin
                                m_pe[s]--; m_pd[s]++;
                            end
                end
            endcase
        end
        for (int h = 0; h < 16; h++) begin
            if (rf[h] && rv[h] > m_crit[h]) m_crit[h] = rv[h];
            else if (wt[h] && m_crit[h] != 0) m_crit[h]--;
        end
        @(posedge clk);
        #1;
        sweep(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished_run) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit [31:0] seed;
        model_clear();
        do_reset();

        // R2 / R3 / R4 / R5: two-instruction group ahead of one-instruction group
        step(1, 0, 1, 0, 0, "R2");
        step(1, 0, 1, 0, 0, "R2");
        step(1, 0, 2, 0, 0, "R2");
        step(1, 1, 1, 2, 0, "R3");
        step(1, 2, 1, 0, 5, "R4");
        step(1, 2, 1, 0, 9, "R4");
        chk("R4", "succ pending", int'(qry_dep), 2);
        qry_gid = 4'd2; #0.1;
        chk("R4", "g2 dep", int'(qry_dep), 1);
        chk("R7", "g2 crit", int'(qry_crit), 9);
        idle(3, "R7");
        step(1, 3, 1, 0, 0, "R5");
        step(1, 3, 1, 0, 0, "R5");
        qry_gid = 4'd2; #0.1;
        chk("R5", "g2 ready", int'(qry_dep), 2);
        step(1, 2, 2, 0, 3, "R4");
        step(1, 3, 2, 0, 0, "R5");

        // R7: waiting group with two predecessors counts down
        step(1, 0, 3, 0, 0, "R2");
        step(1, 0, 5, 0, 0, "R2");
        step(1, 0, 4, 0, 0, "R2");
        step(1, 1, 3, 4, 0, "R3");
        step(1, 1, 5, 4, 0, "R3");
        step(1, 2, 3, 0, 6, "R7");
        idle(4, "R7");
        step(1, 2, 5, 0, 1, "R7");
        idle(3, "R7");
        idle(1, "R6");

        // R3: link to a source already executing
        step(1, 0, 6, 0, 0, "R2");
        step(1, 2, 6, 0, 7, "R4");
        step(1, 0, 7, 0, 0, "R2");
        step(1, 1, 6, 7, 0, "R3");
        qry_gid = 4'd7; #0.1;
        chk("R3", "g7 pend", int'(qry_dep), 1);
        chk("R3", "g7 crit", int'(qry_crit), 7);

        // R8: illegal operations leave state and set sticky flag
        step(1, 0, 1, 0, 0, "R8");
        step(1, 3, 4, 0, 0, "R8");
        step(1, 0, 0, 0, 0, "R8");
        step(1, 2, 2, 0, 4, "R8");
        step(1, 1, 3, 3, 0, "R8");
        step(1, 1, 3, 4, 0, "R8");
        idle(2, "R8");
        for (int i = 0; i < 16; i++) step(1, 0, 8, 0, 0, "R8");
        do_reset();

        // R9: pseudo-random traffic with periodic resets
        seed = 32'h1234_5678;
        for (int i = 0; i < 1500; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (i % 150 == 149) do_reset();
            else step(seed[30:29] != 2'd3, int'(seed[17:16]), int'(seed[22:20]),
                      int'(seed[26:24]), int'(seed[11:8]), "R9");
        end

        finished_run = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule